// File: doc/BRIEF.md
# Banked Interrupt Controller with Normal and Fast Outputs

This block gathers a parameterised number of interrupt request lines, organised in banks of 32, and drives two request outputs toward a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line is synchronised and then sensed either as a level or as a latched edge, in either polarity. It can also be raised by software. Each line is masked by its own enable bit and steered to one of the two outputs.

Software reaches the block through a simple word-wide register port. A write is a single-cycle strobe, and read data is combinational from the address. For every bank there is one word in each of these groups: routing, enable, enable-set alias, enable-clear alias, sensing kind, polarity, normal status, fast status, raw status, acknowledge and software trigger. Two further words are not banked: a two-bit output gate, and a readout of the lowest-numbered line that is requesting on the normal output.

Top module: `intc_dual_route`

## Requirements
- R1: After reset, every routing, enable, kind, polarity and software-trigger bit is 0 and the output gate is 0. Both outputs are low, and the pending readout returns 0xFFFFFFFF.
- R2: Line n lives in bank n/32 at bit n%32. Its word address is the group base plus 4*(n/32). The group bases are: routing 0x00, enable 0x10, enable-clear 0x20, enable-set 0x30, kind 0x40, polarity 0x50, normal status 0x80, fast status 0x90, raw 0xA0, acknowledge 0xB0, software trigger 0xC0. The output gate is at 0x64 and the pending readout is at 0xD0.
- R3: With kind bit 0 (level), the raw bit equals the input XOR the polarity bit (polarity 1 = active low). A change on the input appears within three clocks, because the input passes through two synchroniser flops.
- R4: With kind bit 1 (edge), an active transition latches the raw bit, and the bit stays set after the input returns. The active transition is rising when polarity is 0 and falling when polarity is 1. The inactive transition latches nothing.
- R5: Writing 1 to an acknowledge bit clears that line's edge latch, and 0 bits have no effect. When an active edge is detected in the same cycle as its acknowledge, the latch stays set.
- R6: Writing the enable-set word ORs the written ones into the enables, and writing the enable-clear word removes them. 0 bits leave enables unchanged. Reading either alias returns the enable word.
- R7: A software-trigger bit of 1 sets the line's raw bit whatever the input is.
- R8: Normal status = raw AND enable AND NOT routing. Fast status = raw AND enable AND routing (routing 1 = fast output).
- R9: `irq_o` is high exactly when bit 0 of the output gate is 1 and any normal status bit is set. `fiq_o` does the same with gate bit 1 and the fast status.
- R10: The pending readout returns the index of the lowest-numbered set normal status bit, or 0xFFFFFFFF when none is set.
- R11: Writes to the status, raw and pending addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_in | input | NUM_SRC | Asynchronous interrupt request lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The two events that can coincide are a new active edge, detected by the sensing stage, and a software acknowledge of the same line. The bench provokes this by raising an edge-mode input so that the acknowledge write strobe lands on the exact clock at which the synchronised edge is seen. It then judges the result by reading the raw word: the latch must still be set, and a second acknowledge with no edge must clear it. Random configurations of level-mode lines, mixed with software triggers, are compared against status, outputs and pending index computed by bench functions.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int BANK_W    = 32;
    localparam int MAX_BANKS = 4;

    // Register group selected by address bits [7:4]
    typedef enum logic [3:0] {
        GRP_ROUTE = 4'h0,
        GRP_ENA   = 4'h1,
        GRP_ENCLR = 4'h2,
        GRP_ENSET = 4'h3,
        GRP_KIND  = 4'h4,
        GRP_POL   = 4'h5,
        GRP_CTRL  = 4'h6,
        GRP_IRQST = 4'h8,
        GRP_FIQST = 4'h9,
        GRP_RAW   = 4'hA,
        GRP_ACK   = 4'hB,
        GRP_SOFT  = 4'hC,
        GRP_VEC   = 4'hD
    } grp_e;

    typedef struct packed {
        grp_e       grp;
        logic [1:0] bank;
        logic [1:0] byte_off;
    } addr_t;

    typedef struct packed {
        logic fiq_on;
        logic irq_on;
    } gate_t;

    localparam logic [7:0]  GATE_ADDR = 8'h64;
    localparam logic [7:0]  PEND_ADDR = 8'hD0;
    localparam logic [31:0] PEND_NONE = 32'hFFFF_FFFF;

    function automatic logic [31:0] set_bits(logic [31:0] cur, logic [31:0] w);
        return cur | w;
    endfunction

    function automatic logic [31:0] clr_bits(logic [31:0] cur, logic [31:0] w);
        return cur & ~w;
    endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] irq_st,
    input  logic [NUM_SRC-1:0] fiq_st,
    input  logic [31:0]        pend_num,
    output logic [NUM_SRC-1:0] route_q,
    output logic [NUM_SRC-1:0] ena_q,
    output logic [NUM_SRC-1:0] kind_q,
    output logic [NUM_SRC-1:0] pol_q,
    output logic [NUM_SRC-1:0] soft_q,
    output logic [NUM_SRC-1:0] ack_v,
    output gate_t              gate_q
);

    localparam int NUM_BANKS = NUM_SRC / BANK_W;

    addr_t a;
    assign a = addr_t'(reg_addr);

    // Per-bank configuration words
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = reg_wr && (a.bank == 2'(b)) && (a.byte_off == 2'b00);

        always_ff @(posedge clk) begin
            if (rst) begin
                route_q[b*BANK_W +: BANK_W] <= '0;
                ena_q[b*BANK_W +: BANK_W]   <= '0;
                kind_q[b*BANK_W +: BANK_W]  <= '0;
                pol_q[b*BANK_W +: BANK_W]   <= '0;
                soft_q[b*BANK_W +: BANK_W]  <= '0;
            end else if (hit) begin
                case (a.grp)
                    GRP_ROUTE: route_q[b*BANK_W +: BANK_W] <= reg_wdata;
                    GRP_ENA:   ena_q[b*BANK_W +: BANK_W]   <= reg_wdata;
                    GRP_ENCLR: ena_q[b*BANK_W +: BANK_W]   <=
                                   clr_bits(ena_q[b*BANK_W +: BANK_W], reg_wdata);
                    GRP_ENSET: ena_q[b*BANK_W +: BANK_W]   <=
                                   set_bits(ena_q[b*BANK_W +: BANK_W], reg_wdata);
                    GRP_KIND:  kind_q[b*BANK_W +: BANK_W]  <= reg_wdata;
                    GRP_POL:   pol_q[b*BANK_W +: BANK_W]   <= reg_wdata;
                    GRP_SOFT:  soft_q[b*BANK_W +: BANK_W]  <= reg_wdata;
                    default: ;
                endcase
            end
        end

        assign ack_v[b*BANK_W +: BANK_W] = (hit && a.grp == GRP_ACK) ? reg_wdata : '0;
    end

    // Output gate
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else if (reg_wr && reg_addr == GATE_ADDR) begin
            gate_q <= gate_t'(reg_wdata[1:0]);
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == GATE_ADDR) begin
            reg_rdata = {30'b0, gate_q};
        end else if (reg_addr == PEND_ADDR) begin
            reg_rdata = pend_num;
        end else if (a.byte_off == 2'b00) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (a.bank == 2'(b)) begin
                    case (a.grp)
                        GRP_ROUTE: reg_rdata = route_q[b*BANK_W +: BANK_W];
                        GRP_ENA,
                        GRP_ENCLR,
                        GRP_ENSET: reg_rdata = ena_q[b*BANK_W +: BANK_W];
                        GRP_KIND:  reg_rdata = kind_q[b*BANK_W +: BANK_W];
                        GRP_POL:   reg_rdata = pol_q[b*BANK_W +: BANK_W];
                        GRP_IRQST: reg_rdata = irq_st[b*BANK_W +: BANK_W];
                        GRP_FIQST: reg_rdata = fiq_st[b*BANK_W +: BANK_W];
                        GRP_RAW:   reg_rdata = raw[b*BANK_W +: BANK_W];
                        GRP_SOFT:  reg_rdata = soft_q[b*BANK_W +: BANK_W];
                        default:   reg_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/intc_sense.sv
module intc_sense
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] pol_q,
    input  logic [NUM_SRC-1:0] kind_q,
    input  logic [NUM_SRC-1:0] ack_v,
    output logic [NUM_SRC-1:0] hw_raw
);

    localparam int NUM_BANKS = NUM_SRC / BANK_W;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] meta_q, sync_q, prev_q, lat_q;
        logic [BANK_W-1:0] act, edge_hit;

        // Polarity-corrected level, then a one-cycle active-edge pulse
        assign act      = sync_q ^ pol_q[b*BANK_W +: BANK_W];
        assign edge_hit = act & ~prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= '0;
                sync_q <= '0;
                prev_q <= '0;
                lat_q  <= '0;
            end else begin
                meta_q <= src_in[b*BANK_W +: BANK_W];
                sync_q <= meta_q;
                prev_q <= act;
                // A new edge wins over an acknowledge in the same cycle
                lat_q  <= (lat_q & ~ack_v[b*BANK_W +: BANK_W])
                        | (edge_hit & kind_q[b*BANK_W +: BANK_W]);
            end
        end

        assign hw_raw[b*BANK_W +: BANK_W] =
              (kind_q[b*BANK_W +: BANK_W] & lat_q)
            | (~kind_q[b*BANK_W +: BANK_W] & act);
    end

endmodule

// File: rtl/intc_route.sv
module intc_route
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] raw,
    input  logic [NUM_SRC-1:0] ena_q,
    input  logic [NUM_SRC-1:0] route_q,
    input  gate_t              gate_q,
    output logic [NUM_SRC-1:0] irq_st,
    output logic [NUM_SRC-1:0] fiq_st,
    output logic               irq_o,
    output logic               fiq_o,
    output logic [31:0]        pend_num
);

    assign irq_st = raw & ena_q & ~route_q;
    assign fiq_st = raw & ena_q &  route_q;

    assign irq_o = gate_q.irq_on & (|irq_st);
    assign fiq_o = gate_q.fiq_on & (|fiq_st);

    // Lowest-numbered normal request wins
    always_comb begin
        pend_num = PEND_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (irq_st[i]) pend_num = 32'(i);
        end
    end

endmodule

// File: rtl/intc_dual_route.sv
module intc_dual_route
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_o,
    output logic               fiq_o
);

    localparam int NUM_BANKS = NUM_SRC / BANK_W;

    initial begin
        if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS || NUM_SRC % BANK_W != 0)
            $error("NUM_SRC must be 32, 64, 96 or 128");
    end

    logic [NUM_SRC-1:0] route_q, ena_q, kind_q, pol_q, soft_q, ack_v;
    logic [NUM_SRC-1:0] hw_raw, raw, irq_st, fiq_st;
    logic [31:0]        pend_num;
    gate_t              gate_q;

    assign raw = hw_raw | soft_q;

    intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .raw      (raw),
        .irq_st   (irq_st),
        .fiq_st   (fiq_st),
        .pend_num (pend_num),
        .route_q  (route_q),
        .ena_q    (ena_q),
        .kind_q   (kind_q),
        .pol_q    (pol_q),
        .soft_q   (soft_q),
        .ack_v    (ack_v),
        .gate_q   (gate_q)
    );

    intc_sense #(.NUM_SRC(NUM_SRC)) u_sense (
        .clk   (clk),
        .rst   (rst),
        .src_in(src_in),
        .pol_q (pol_q),
        .kind_q(kind_q),
        .ack_v (ack_v),
        .hw_raw(hw_raw)
    );

    intc_route #(.NUM_SRC(NUM_SRC)) u_route (
        .raw     (raw),
        .ena_q   (ena_q),
        .route_q (route_q),
        .gate_q  (gate_q),
        .irq_st  (irq_st),
        .fiq_st  (fiq_st),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o),
        .pend_num(pend_num)
    );

endmodule

// File: rtl/intc_dual_route_chk.sv
module intc_dual_route_chk #(
    parameter int NUM_SRC = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [7:0]         reg_addr,
    input logic [31:0]        reg_wdata,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [1:0]         gate_bits,
    input logic [31:0]        ena_lo,
    input logic [NUM_SRC-1:0] irq_st,
    input logic [31:0]        pend_num
);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> gate_bits[0]);

    assert_fiq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> gate_bits[1]);

    assert_enable_set_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 8'h30) |=> ((ena_lo & $past(reg_wdata)) == $past(reg_wdata)));

    assert_enable_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 8'h20) |=> ((ena_lo & $past(reg_wdata)) == 32'h0));

    assert_pend_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_st == '0) |-> (pend_num == 32'hFFFF_FFFF));

    assert_pend_range_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_st != '0) |-> (pend_num < NUM_SRC));

endmodule

bind intc_dual_route intc_dual_route_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .gate_bits(gate_q),
    .ena_lo   (ena_q[31:0]),
    .irq_st   (irq_st),
    .pend_num (pend_num)
);

// File: tb/intc_dual_route_test.sv
module intc_dual_route_test;

    localparam int NSRC = 64;
    localparam int NB   = NSRC / 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NSRC-1:0] src = '0;
    logic            irq_o, fiq_o;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    // Bench model
    logic [31:0] m_route [NB];
    logic [31:0] m_ena   [NB];
    logic [31:0] m_kind  [NB];
    logic [31:0] m_pol   [NB];
    logic [31:0] m_soft  [NB];
    logic [31:0] m_lat   [NB];
    logic [1:0]  m_gate;

    always #5 clk = ~clk;

    intc_dual_route #(.NUM_SRC(NSRC)) uut (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .src_in   (src),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o)
    );

    function automatic logic [7:0] ad(int grp, int b);
        return 8'((grp << 4) | (b << 2));
    endfunction

    function automatic logic [31:0] exp_raw(int b);
        logic [31:0] lvl;
        lvl = src[b*32 +: 32] ^ m_pol[b];
        return (m_kind[b] & m_lat[b]) | (~m_kind[b] & lvl) | m_soft[b];
    endfunction

    function automatic logic [31:0] exp_irq(int b);
        return exp_raw(b) & m_ena[b] & ~m_route[b];
    endfunction

    function automatic logic [31:0] exp_fiq(int b);
        return exp_raw(b) & m_ena[b] & m_route[b];
    endfunction

    function automatic logic [31:0] exp_pend();
        logic [31:0] p;
        p = 32'hFFFF_FFFF;
        for (int i = NSRC - 1; i >= 0; i--) begin
            logic [31:0] w;
            w = exp_irq(i / 32);
            if (w[i % 32]) p = 32'(i);
        end
        return p;
    endfunction

    function automatic logic exp_irq_o();
        logic any;
        any = 1'b0;
        for (int b = 0; b < NB; b++) any = any | (|exp_irq(b));
        return any & m_gate[0];
    endfunction

    function automatic logic exp_fiq_o();
        logic any;
        any = 1'b0;
        for (int b = 0; b < NB; b++) any = any | (|exp_fiq(b));
        return any & m_gate[1];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge
    task automatic wr(logic [7:0] addr, logic [31:0] data);
        reg_addr  = addr;
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] addr, output logic [31:0] data);
        reg_addr = addr;
        #1;
        data = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        for (int b = 0; b < NB; b++) begin
            rd(ad(4'hA, b), d); check({tag, " R3 raw"}, d, exp_raw(b));
            rd(ad(4'h8, b), d); check({tag, " R8 irq status"}, d, exp_irq(b));
            rd(ad(4'h9, b), d); check({tag, " R8 fiq status"}, d, exp_fiq(b));
        end
        rd(8'hD0, d); check({tag, " R10 pending"}, d, exp_pend());
        check({tag, " R9 irq_o"}, {31'b0, irq_o}, {31'b0, exp_irq_o()});
        check({tag, " R9 fiq_o"}, {31'b0, fiq_o}, {31'b0, exp_fiq_o()});
    endtask

    task automatic zero_cfg();
        for (int b = 0; b < NB; b++) begin
            m_route[b] = '0; m_ena[b] = '0; m_kind[b] = '0;
            m_pol[b] = '0; m_soft[b] = '0; m_lat[b] = '0;
            wr(ad(4'h0, b), 0); wr(ad(4'h1, b), 0); wr(ad(4'h4, b), 0);
            wr(ad(4'h5, b), 0); wr(ad(4'hC, b), 0); wr(ad(4'hB, b), 32'hFFFF_FFFF);
        end
        m_gate = 2'b00;
        wr(8'h64, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin
            m_route[b] = '0; m_ena[b] = '0; m_kind[b] = '0;
            m_pol[b] = '0; m_soft[b] = '0; m_lat[b] = '0;
        end
        m_gate = 2'b00;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int b = 0; b < NB; b++) begin
            rd(ad(4'h0, b), d); check("R1 routing", d, 0);
            rd(ad(4'h1, b), d); check("R1 enable", d, 0);
            rd(ad(4'h4, b), d); check("R1 kind", d, 0);
            rd(ad(4'h5, b), d); check("R1 polarity", d, 0);
            rd(ad(4'hC, b), d); check("R1 soft", d, 0);
        end
        rd(8'h64, d); check("R1 gate", d, 0);
        rd(8'hD0, d); check("R1 pending none", d, 32'hFFFF_FFFF);
        check("R1 irq_o", {31'b0, irq_o}, 0);
        check("R1 fiq_o", {31'b0, fiq_o}, 0);

        // R2: bank addressing
        wr(ad(4'h0, 1), 32'h5A5A_0F0F); m_route[1] = 32'h5A5A_0F0F;
        rd(ad(4'h0, 1), d); check("R2 bank1 routing", d, 32'h5A5A_0F0F);
        rd(ad(4'h0, 0), d); check("R2 bank0 untouched", d, 0);

        // R6: enable aliases
        wr(ad(4'h1, 0), 32'hF0F0_0000);
        wr(ad(4'h3, 0), 32'h0000_00FF);
        rd(ad(4'h1, 0), d); check("R6 set alias", d, 32'hF0F0_00FF);
        rd(ad(4'h3, 0), d); check("R6 read set alias", d, 32'hF0F0_00FF);
        wr(ad(4'h2, 0), 32'hF000_000F);
        rd(ad(4'h2, 0), d); check("R6 clear alias", d, 32'h00F0_00F0);
        wr(ad(4'h3, 1), 32'h0000_0003);
        rd(ad(4'h1, 1), d); check("R6 set alias bank1", d, 32'h0000_0003);
        m_ena[0] = 32'h00F0_00F0; m_ena[1] = 32'h0000_0003;

        // Random level-mode configurations: R3 R8 R9 R10
        for (int it = 0; it < 30; it++) begin
            for (int b = 0; b < NB; b++) begin
                logic [31:0] v;
                int mode;
                m_route[b] = $urandom;
                m_pol[b]   = $urandom & $urandom & $urandom;
                m_soft[b]  = $urandom & $urandom & $urandom & $urandom;
                src[b*32 +: 32] = $urandom & $urandom & $urandom;
                wr(ad(4'h0, b), m_route[b]);
                wr(ad(4'h5, b), m_pol[b]);
                wr(ad(4'hC, b), m_soft[b]);
                v = $urandom;
                mode = int'($urandom % 3);
                if (mode == 0) begin m_ena[b] = v; wr(ad(4'h1, b), v); end
                else if (mode == 1) begin m_ena[b] |= v; wr(ad(4'h3, b), v); end
                else begin m_ena[b] &= ~v; wr(ad(4'h2, b), v); end
            end
            m_gate = 2'($urandom);
            wr(8'h64, {30'b0, m_gate});
            settle();
            check_all("random");
        end

        // R11: writes to read-only addresses
        for (int b = 0; b < NB; b++) begin
            wr(ad(4'hA, b), 32'hFFFF_FFFF);
            wr(ad(4'h8, b), 32'hFFFF_FFFF);
            wr(ad(4'h9, b), 32'hFFFF_FFFF);
        end
        wr(8'hD0, 32'h0000_0000);
        for (int b = 0; b < NB; b++) begin
            rd(ad(4'hA, b), d); check("R11 raw unchanged", d, exp_raw(b));
            rd(ad(4'h1, b), d); check("R11 enable unchanged", d, m_ena[b]);
        end
        rd(8'hD0, d); check("R11 pending unchanged", d, exp_pend());

        // R7 and R10: software triggers and priority
        src = '0;
        zero_cfg();
        m_soft[1] = 32'h0000_0020; wr(ad(4'hC, 1), m_soft[1]);
        m_ena[1]  = 32'h0000_0020; wr(ad(4'h1, 1), m_ena[1]);
        m_gate = 2'b11; wr(8'h64, 32'h3);
        settle();
        rd(ad(4'hA, 1), d); check("R7 soft raw", d, 32'h0000_0020);
        rd(8'hD0, d); check("R10 pending 37", d, 37);
        m_soft[0] = 32'h0000_0008; wr(ad(4'hC, 0), m_soft[0]);
        m_ena[0]  = 32'h0000_0008; wr(ad(4'h1, 0), m_ena[0]);
        rd(8'hD0, d); check("R10 lowest wins", d, 3);
        m_route[0] = 32'h0000_0008; wr(ad(4'h0, 0), m_route[0]);
        rd(8'hD0, d); check("R10 fast-routed skipped", d, 37);
        check("R9 fiq_o", {31'b0, fiq_o}, 1);
        check_all("R7 mix");

        // R4 and R5: edge sensing on lines 40 (rising) and 41 (falling)
        zero_cfg();
        m_gate = 2'b11; wr(8'h64, 32'h3);
        m_pol[1]  = 32'h0000_0200; wr(ad(4'h5, 1), m_pol[1]);
        m_kind[1] = 32'h0000_0300; wr(ad(4'h4, 1), m_kind[1]);
        m_ena[1]  = 32'h0000_0300; wr(ad(4'h1, 1), m_ena[1]);
        settle();
        rd(ad(4'hA, 1), d); check("R4 no edge yet", d, 0);
        src[40] = 1'b1; settle(); m_lat[1] |= 32'h0000_0100;
        rd(ad(4'hA, 1), d); check("R4 rising latched", d, 32'h0000_0100);
        src[40] = 1'b0; settle();
        rd(ad(4'hA, 1), d); check("R4 latch holds", d, 32'h0000_0100);
        src[41] = 1'b1; settle();
        rd(ad(4'hA, 1), d); check("R4 inactive edge ignored", d, 32'h0000_0100);
        src[41] = 1'b0; settle(); m_lat[1] |= 32'h0000_0200;
        rd(ad(4'hA, 1), d); check("R4 falling latched", d, 32'h0000_0300);
        wr(ad(4'hB, 1), 32'h0000_0100); m_lat[1] &= ~32'h0000_0100;
        rd(ad(4'hA, 1), d); check("R5 ack one bit", d, 32'h0000_0200);
        wr(ad(4'hB, 1), 32'h0);
        rd(ad(4'hA, 1), d); check("R5 zero ack no effect", d, 32'h0000_0200);
        wr(ad(4'hB, 1), 32'h0000_0200); m_lat[1] = '0;
        rd(ad(4'hA, 1), d); check("R5 ack second bit", d, 0);
        check_all("R5 after ack");

        // R5: acknowledge lands on the clock that detects a new edge
        src[40] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr(ad(4'hB, 1), 32'h0000_0100);
        m_lat[1] = 32'h0000_0100;
        rd(ad(4'hA, 1), d); check("R5 edge beats ack", d, 32'h0000_0100);
        settle();
        check_all("R5 collision");
        wr(ad(4'hB, 1), 32'h0000_0100); m_lat[1] = '0;
        rd(ad(4'hA, 1), d); check("R5 later ack clears", d, 0);

        // R9: gate blocks the normal output
        src[40] = 1'b0; settle();
        src[40] = 1'b1; settle(); m_lat[1] = 32'h0000_0100;
        m_gate = 2'b10; wr(8'h64, 32'h2);
        rd(ad(4'h8, 1), d); check("R9 status still set", d, 32'h0000_0100);
        check("R9 irq_o gated off", {31'b0, irq_o}, 0);
        m_gate = 2'b01; wr(8'h64, 32'h1);
        check("R9 irq_o gated on", {31'b0, irq_o}, 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule